// File: doc/BRIEF.md
# Dual-Period Watchdog Timer with Reset Option

This block is a free-running watchdog for an embedded bus controller. A prescaler divides the system clock into a coarse tick. A tick counter then measures one of two periods, and a single control bit picks between them. When the selected period runs out, the block does one of two things. It can latch a watchdog event, which can then drive a level interrupt request. Or it can emit a one-cycle request for a full hardware reset, which an external reset sequencer acts on.

Host software owns three control bits: a fast-period select, a reset-on-expiry enable and an interrupt enable. It also has a clear strobe for the latched event. A read strobe from the host, issued as the side effect of reading the status/control register, restarts the whole count. Software keeps the board alive by reading that register more often than the selected period. The period lengths are parameters, so they can be set from the clock frequency (long values on silicon, short values in simulation).

Top module: `wdog_dual_period`

## Requirements
- R1: While `rst_n` is low and after it is released, `cfg_fast`, `cfg_rst_en`, `cfg_evt_en`, `evt_flag`, `irq` and `rst_req` are all 0, so the long period is selected and reset-on-expiry is disabled.
- R2: With `cfg_fast` = 0, expiry becomes visible on the outputs exactly `SLOW_TICKS*PRESCALE` clock edges after the edge that sampled a restart, and not one edge earlier.
- R3: With `cfg_fast` = 1, expiry becomes visible exactly `FAST_TICKS*PRESCALE` clock edges after the restart edge.
- R4: With `cfg_rst_en` = 0, expiry sets `evt_flag` and leaves `rst_req` low.
- R5: `irq` is high exactly when `evt_flag` and `cfg_evt_en` are both 1. The event latches even while the enable is 0, and it raises `irq` as soon as the enable is set.
- R6: `evt_flag` stays set until a cycle with `evt_clr` = 1, which clears it on that edge. If an expiry and a clear coincide, the set wins.
- R7: A cycle with `rd_strobe` = 1 clears both the prescaler and the tick counter, so the next expiry is a full period after that edge.
- R8: With `cfg_rst_en` = 1, expiry drives `rst_req` high and does not set `evt_flag`.
- R9: `rst_req` is high for exactly one cycle. The count reloads on expiry, so with no restart the next expiry follows one full period later.
- R10: A `rd_strobe` sampled on the same edge on which the count would expire cancels that expiry: no `rst_req` and no event.
- R11: If the fast period is selected while the tick count is already at or beyond the fast limit, expiry happens on the next prescaler tick.
- R12: A register write (`wr_en` = 1) loads `cfg_fast`, `cfg_rst_en` and `cfg_evt_en` from `wr_fast`, `wr_rst_en` and `wr_evt_en` on the next edge and does not restart the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low full hardware reset |
| wr_en | input | 1 | Control register write strobe |
| wr_fast | input | 1 | Write data: fast-period select |
| wr_rst_en | input | 1 | Write data: reset-on-expiry enable |
| wr_evt_en | input | 1 | Write data: event interrupt enable |
| rd_strobe | input | 1 | Status/control read side effect; restarts the count |
| evt_clr | input | 1 | Clears the latched watchdog event |
| cfg_fast | output | 1 | Current fast-period select |
| cfg_rst_en | output | 1 | Current reset-on-expiry enable |
| cfg_evt_en | output | 1 | Current event interrupt enable |
| evt_flag | output | 1 | Latched watchdog event |
| irq | output | 1 | Level interrupt request |
| rst_req | output | 1 | One-cycle hardware reset request |

## Verification
Two situations are hard to reach from the ports. The first is a restart read that lands on the very edge of expiry. The second is a switch to the short period while the count already sits past the short limit. Both depend on knowing the internal tick count, which is never brought out. The bench gets there by issuing a restart and then counting clock edges from it, using the known period times the prescale ratio. It places the read strobe, or the period-select write, on a computed edge: at the expiry edge itself, or deep into a long period. The outputs are then checked on the edges just before and just after the predicted expiry.

// File: rtl/wdog_dual_period.sv
module wdog_dual_period #(
  parameter int PRESCALE   = 100000,
  parameter int FAST_TICKS = 210,
  parameter int SLOW_TICKS = 6700
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_fast,
  input  logic wr_rst_en,
  input  logic wr_evt_en,
  input  logic rd_strobe,
  input  logic evt_clr,
  output logic cfg_fast,
  output logic cfg_rst_en,
  output logic cfg_evt_en,
  output logic evt_flag,
  output logic irq,
  output logic rst_req
);
  localparam int PW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam int TW = $clog2(SLOW_TICKS + 1);

  logic [PW-1:0] presc_q;
  logic [TW-1:0] ticks_q;
  logic          tick;
  logic          expire;
  logic [TW-1:0] limit_m1;

  assign tick     = (presc_q == PW'(PRESCALE - 1));
  assign limit_m1 = cfg_fast ? TW'(FAST_TICKS - 1) : TW'(SLOW_TICKS - 1);
  assign expire   = tick && (ticks_q >= limit_m1) && !rd_strobe;
  assign irq      = evt_flag && cfg_evt_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= '0;
      ticks_q <= '0;
    end else if (rd_strobe) begin
      presc_q <= '0;
      ticks_q <= '0;
    end else if (tick) begin
      presc_q <= '0;
      ticks_q <= expire ? '0 : ticks_q + TW'(1);
    end else begin
      presc_q <= presc_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_fast   <= 1'b0;
      cfg_rst_en <= 1'b0;
      cfg_evt_en <= 1'b0;
      evt_flag   <= 1'b0;
      rst_req    <= 1'b0;
    end else begin
      if (wr_en) begin
        cfg_fast   <= wr_fast;
        cfg_rst_en <= wr_rst_en;
        cfg_evt_en <= wr_evt_en;
      end
      rst_req <= expire && cfg_rst_en;
      if (expire && !cfg_rst_en) evt_flag <= 1'b1;
      else if (evt_clr)          evt_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/wdog_dual_period_chk.sv
module wdog_dual_period_chk (
  input logic clk,
  input logic rst_n,
  input logic rd_strobe,
  input logic evt_clr,
  input logic cfg_rst_en,
  input logic evt_flag,
  input logic rst_req
);
  assert_pulse_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  assert_reset_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(cfg_rst_en));

  assert_event_only_without_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_flag) |-> !$past(cfg_rst_en));

  assert_event_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_flag && !evt_clr) |=> evt_flag);

  assert_restart_cancels_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |=> (!rst_req && !$rose(evt_flag)));

  assert_no_dual_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_req && $rose(evt_flag)));
endmodule

bind wdog_dual_period wdog_dual_period_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_strobe  (rd_strobe),
  .evt_clr    (evt_clr),
  .cfg_rst_en (cfg_rst_en),
  .evt_flag   (evt_flag),
  .rst_req    (rst_req)
);

// File: tb/wdog_dual_period_bench.sv
module wdog_dual_period_bench;
  localparam int P  = 4;
  localparam int FT = 5;
  localparam int ST = 12;
  localparam int FAST_CYC = FT * P;
  localparam int SLOW_CYC = ST * P;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_fast = 1'b0, wr_rst_en = 1'b0, wr_evt_en = 1'b0;
  logic rd_strobe = 1'b0, evt_clr = 1'b0;
  logic cfg_fast, cfg_rst_en, cfg_evt_en, evt_flag, irq, rst_req;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  wdog_dual_period #(.PRESCALE(P), .FAST_TICKS(FT), .SLOW_TICKS(ST)) u_wdog_dual_period (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_fast(wr_fast), .wr_rst_en(wr_rst_en),
    .wr_evt_en(wr_evt_en), .rd_strobe(rd_strobe), .evt_clr(evt_clr),
    .cfg_fast(cfg_fast), .cfg_rst_en(cfg_rst_en), .cfg_evt_en(cfg_evt_en),
    .evt_flag(evt_flag), .irq(irq), .rst_req(rst_req)
  );

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic restart();
    rd_strobe = 1'b1;
    step(1);
    rd_strobe = 1'b0;
  endtask

  task automatic write_cfg(input logic f, input logic r, input logic e);
    wr_en = 1'b1; wr_fast = f; wr_rst_en = r; wr_evt_en = e;
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic clear_evt();
    evt_clr = 1'b1;
    step(1);
    evt_clr = 1'b0;
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0;
    step(3);
    rst_n = 1'b1;
    chk("R1", "cfg_fast", cfg_fast, 1'b0);
    chk("R1", "cfg_rst_en", cfg_rst_en, 1'b0);
    chk("R1", "cfg_evt_en", cfg_evt_en, 1'b0);
    chk("R1", "evt_flag", evt_flag, 1'b0);
    chk("R1", "irq", irq, 1'b0);
    chk("R1", "rst_req", rst_req, 1'b0);
  endtask

  task automatic t_slow_period();
    restart();
    step(10);
    write_cfg(1'b0, 1'b0, 1'b1);
    chk("R12", "cfg_evt_en after write", cfg_evt_en, 1'b1);
    step(SLOW_CYC - 1 - 11);
    chk("R2", "evt_flag one edge early", evt_flag, 1'b0);
    step(1);
    chk("R2", "evt_flag at slow expiry", evt_flag, 1'b1);
    chk("R4", "rst_req without reset enable", rst_req, 1'b0);
    chk("R5", "irq with enable", irq, 1'b1);
  endtask

  task automatic t_latch_and_clear();
    write_cfg(1'b0, 1'b0, 1'b0);
    chk("R5", "irq masked", irq, 1'b0);
    chk("R5", "evt_flag latched while masked", evt_flag, 1'b1);
    step(5);
    write_cfg(1'b0, 1'b0, 1'b1);
    chk("R6", "evt_flag still held", evt_flag, 1'b1);
    chk("R5", "irq after unmask", irq, 1'b1);
    clear_evt();
    chk("R6", "evt_flag cleared", evt_flag, 1'b0);
    chk("R5", "irq after clear", irq, 1'b0);
  endtask

  task automatic t_fast_and_restart();
    write_cfg(1'b1, 1'b0, 1'b1);
    restart();
    step(15);
    restart();
    step(FAST_CYC - 1);
    chk("R7", "no expiry before full period after restart", evt_flag, 1'b0);
    step(1);
    chk("R3", "evt_flag at fast expiry", evt_flag, 1'b1);
    chk("R7", "irq at restarted expiry", irq, 1'b1);
    clear_evt();
  endtask

  task automatic t_reset_mode();
    write_cfg(1'b1, 1'b1, 1'b1);
    restart();
    step(FAST_CYC - 1);
    chk("R8", "rst_req one edge early", rst_req, 1'b0);
    step(1);
    chk("R8", "rst_req at expiry", rst_req, 1'b1);
    chk("R8", "evt_flag not set in reset mode", evt_flag, 1'b0);
    step(1);
    chk("R9", "rst_req drops after one cycle", rst_req, 1'b0);
    step(FAST_CYC - 2);
    chk("R9", "no second pulse early", rst_req, 1'b0);
    step(1);
    chk("R9", "second pulse after reload", rst_req, 1'b1);
  endtask

  task automatic t_restart_at_expiry();
    write_cfg(1'b1, 1'b0, 1'b1);
    clear_evt();
    restart();
    step(FAST_CYC - 1);
    rd_strobe = 1'b1;
    step(1);
    rd_strobe = 1'b0;
    chk("R10", "evt_flag cancelled by restart", evt_flag, 1'b0);
    chk("R10", "rst_req cancelled by restart", rst_req, 1'b0);
    step(FAST_CYC - 1);
    chk("R10", "no early expiry", evt_flag, 1'b0);
    step(1);
    chk("R10", "expiry one period after cancel", evt_flag, 1'b1);
    clear_evt();
  endtask

  task automatic t_shorten_late();
    write_cfg(1'b0, 1'b0, 1'b1);
    restart();
    step(39);
    write_cfg(1'b1, 1'b0, 1'b1);
    step(3);
    chk("R11", "no expiry before next tick", evt_flag, 1'b0);
    step(1);
    chk("R11", "expiry on next tick after shortening", evt_flag, 1'b1);
  endtask

  task automatic t_reset_clears();
    write_cfg(1'b1, 1'b1, 1'b1);
    rst_n = 1'b0;
    step(2);
    rst_n = 1'b1;
    chk("R1", "cfg_fast after reset", cfg_fast, 1'b0);
    chk("R1", "cfg_rst_en after reset", cfg_rst_en, 1'b0);
    chk("R1", "evt_flag after reset", evt_flag, 1'b0);
  endtask

  initial begin
    step(1);
    t_reset_state();
    t_slow_period();
    t_latch_and_clear();
    t_fast_and_restart();
    t_reset_mode();
    t_restart_at_expiry();
    t_shorten_late();
    t_reset_clears();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule